// File: doc/BRIEF.md
# Flag-Generating Add/Subtract/Compare Unit

This block is the integer add/subtract slice of a 64-bit execution datapath. Each cycle it accepts one operation: add, subtract, compare or no-op. The first operand comes from a register. The second comes either from a register or from an immediate, chosen per operation. The sum or difference appears combinationally on the result port. A write-enable tells the register file whether to commit that result. Compare performs the subtraction but never raises the write-enable.

Add, subtract and compare produce six status bits, which are captured in a flag register on the clock edge:
- carry/borrow
- low-byte parity
- nibble adjust
- zero
- sign
- signed overflow

A condition decoder reads only the stored flags. It reports signed greater, equal and signed less, plus an unsigned below, so that a conditional branch issued later can act on them.

Top module: `flag_alu`

## Requirements
- R1: With `op_valid`=1 and `op_sel`=2'b00 (add), `result` equals A+B modulo 2^64 and `result_we` is 1 in the same cycle.
- R2: With `op_valid`=1 and `op_sel`=2'b01 (subtract), `result` equals A−B modulo 2^64 and `result_we` is 1 in the same cycle.
- R3: With `op_sel`=2'b10 (compare), `result_we` is 0, and the flags captured are exactly those a subtract of the same operands would capture. `op_sel`=2'b11 is a no-op, and `result_we` is also 0 whenever `op_valid` is 0.
- R4: The flag vector `flags_q` is laid out as {OF, SF, ZF, AF, PF, CF} in bits 5..0. ZF is 1 exactly when the 64-bit result is zero. SF is a copy of result bit 63.
- R5: CF is the carry out of bit 63 on add. On subtract and compare it is the borrow, which is 1 exactly when A < B unsigned.
- R6: OF is 1 when the signed result overflows. On add this means both operands have the same sign and the result has the other sign. On subtract and compare it means the operands differ in sign and the result's sign differs from A's.
- R7: PF is 1 when result bits 7..0 hold an even number of ones. AF is the carry out of bit 3 on add, or the borrow into bit 4 on subtract and compare.
- R8: `flags_q` loads only on a clock edge where `op_valid`=1 and `op_sel` is add, subtract or compare. Otherwise it holds. Reset clears it to zero.
- R9: The condition outputs are decoded from `flags_q` alone:
  - `cond_eq` = ZF
  - `cond_lt` = !ZF & (SF^OF)
  - `cond_gt` = !ZF & !(SF^OF)
  - `cond_below` = CF
- R10: B is `imm_val` when `use_imm`=1 and `src_b` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 2 | 00 add, 01 subtract, 10 compare, 11 no-op |
| use_imm | input | 1 | Select immediate as operand B |
| src_a | input | 64 | Operand A |
| src_b | input | 64 | Register operand B |
| imm_val | input | 64 | Immediate operand B |
| result | output | 64 | Sum or difference (combinational) |
| result_we | output | 1 | Commit result (add or subtract only) |
| flags_q | output | 6 | Stored flags {OF,SF,ZF,AF,PF,CF} |
| cond_gt | output | 1 | Signed greater, from stored flags |
| cond_eq | output | 1 | Equal, from stored flags |
| cond_lt | output | 1 | Signed less, from stored flags |
| cond_below | output | 1 | Unsigned below, from stored flags |

## Verification
The bench compares against the most negative value minus one and against one minus it. A design that tests the sign flag alone for "less than" would report the wrong ordering in those cases, as would one whose overflow term for subtraction uses the uncomplemented B. All-ones plus one and zero minus one exercise carry versus borrow polarity, and 0x0F/0x10 nibble patterns separate a correct bit-3 adjust from an off-by-one bit. Compares and no-ops are interleaved with adds, which would expose a compare that raises the write-enable or a no-op that disturbs the stored flags and the conditions derived from them.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_CMP = 2'b10,
    OP_NOP = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic adj;
    logic par;
    logic cry;
  } alu_flags_t;

  localparam int unsigned FLAG_W = 6;

endpackage

// File: rtl/flag_alu_rst_sync.sv
module flag_alu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign sync_d[i] = 1'b1;
      end else begin : g_rest
        assign sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub
  import flag_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned PAR_W   = 8,
  parameter int unsigned ADJ_BIT = 4
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              do_sub,
  output logic [DATA_W-1:0] sum,
  output alu_flags_t        flags
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] opb_eff;
  logic [DATA_W-1:0] carry_vec;
  logic              cout;

  always_comb begin
    opb_eff       = do_sub ? ~opb : opb;
    {cout, sum}   = {1'b0, opa} + {1'b0, opb_eff} + {{DATA_W{1'b0}}, do_sub};
    carry_vec     = opa ^ opb ^ sum;
    flags.cry     = cout ^ do_sub;
    flags.adj     = carry_vec[ADJ_BIT];
    flags.par     = ~^sum[PAR_W-1:0];
    flags.zro     = (sum == '0);
    flags.sgn     = sum[MSB];
    flags.ovf     = (opa[MSB] == opb_eff[MSB]) && (sum[MSB] != opa[MSB]);
  end

endmodule

// File: rtl/flag_alu_flagreg.sv
module flag_alu_flagreg
  import flag_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  alu_flags_t flags_in,
  output alu_flags_t flags_q
);

  alu_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (load) flags_d = flags_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R8: no load means the stored flags stay put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(flags_q));

endmodule

// File: rtl/flag_alu_cond.sv
module flag_alu_cond
  import flag_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  alu_flags_t flags,
  output logic       gt,
  output logic       eq,
  output logic       lt,
  output logic       below
);

  logic sgn_lt;

  always_comb begin
    sgn_lt = flags.sgn ^ flags.ovf;
    eq     = flags.zro;
    lt     = ~flags.zro & sgn_lt;
    gt     = ~flags.zro & ~sgn_lt;
    below  = flags.cry;
  end

  // R9: exactly one signed ordering holds
  p_order_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gt, eq, lt}) == 1);

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned PAR_W   = 8,
  parameter int unsigned ADJ_BIT = 4,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_sel,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] imm_val,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic [FLAG_W-1:0] flags_q,
  output logic              cond_gt,
  output logic              cond_eq,
  output logic              cond_lt,
  output logic              cond_below
);

  alu_op_e           op;
  logic              rst_sync_n;
  logic [DATA_W-1:0] opb_sel;
  logic              do_sub;
  logic              flag_load;
  alu_flags_t        new_flags;
  alu_flags_t        cur_flags;

  flag_alu_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    op        = alu_op_e'(op_sel);
    opb_sel   = use_imm ? imm_val : src_b;
    do_sub    = (op != OP_ADD);
    flag_load = op_valid && (op != OP_NOP);
    result_we = op_valid && ((op == OP_ADD) || (op == OP_SUB));
  end

  flag_alu_addsub #(.DATA_W(DATA_W), .PAR_W(PAR_W), .ADJ_BIT(ADJ_BIT)) u_core (
    .opa    (src_a),
    .opb    (opb_sel),
    .do_sub (do_sub),
    .sum    (result),
    .flags  (new_flags)
  );

  flag_alu_flagreg u_freg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (flag_load),
    .flags_in (new_flags),
    .flags_q  (cur_flags)
  );

  assign flags_q = cur_flags;

  flag_alu_cond u_cond (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .flags (cur_flags),
    .gt    (cond_gt),
    .eq    (cond_eq),
    .lt    (cond_lt),
    .below (cond_below)
  );

  // R3: a compare never commits its difference
  p_cmp_no_we_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_sel == OP_CMP) |-> !result_we);

  // R4: stored zero flag reflects the previous result
  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_load |=> (cur_flags.zro == ($past(result) == '0)));

  // R5: borrow after subtract/compare equals unsigned A < B
  p_borrow_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_load && op_sel != OP_ADD) |=> (cur_flags.cry == ($past(src_a) < $past(opb_sel))));

  // R1: add result commits
  p_add_we_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_sel == OP_ADD) |-> result_we);

endmodule

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_sel;
  logic        use_imm;
  logic [63:0] src_a, src_b, imm_val;
  logic [63:0] result;
  logic        result_we;
  logic [5:0]  flags_q;
  logic        cond_gt, cond_eq, cond_lt, cond_below;

  int n_checks = 0;
  int n_fail   = 0;
  logic [5:0] exp_flags;
  bit done = 0;

  flag_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .use_imm(use_imm), .src_a(src_a), .src_b(src_b), .imm_val(imm_val),
    .result(result), .result_we(result_we), .flags_q(flags_q),
    .cond_gt(cond_gt), .cond_eq(cond_eq), .cond_lt(cond_lt), .cond_below(cond_below)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference flags {OF,SF,ZF,AF,PF,CF}
  function automatic logic [5:0] ref_flags(input bit sub, input logic [63:0] a, input logic [63:0] b);
    logic [64:0] wide;
    logic [63:0] r;
    logic cf, af, of;
    if (!sub) begin
      wide = {1'b0, a} + {1'b0, b};
      r = wide[63:0];
      cf = wide[64];
      af = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
      of = (a[63] == b[63]) && (r[63] != a[63]);
    end else begin
      r = a - b;
      cf = a < b;
      af = a[3:0] < b[3:0];
      of = (a[63] != b[63]) && (r[63] != a[63]);
    end
    return {of, r[63], (r == 64'd0), af, ($countones(r[7:0]) % 2 == 0), cf};
  endfunction

  task automatic apply(input logic v, input logic [1:0] op, input logic [63:0] a,
                       input logic [63:0] breg, input logic [63:0] imm, input logic ui);
    logic [63:0] b, er;
    logic [5:0]  f;
    bit lt, eq;
    @(negedge clk);
    op_valid = v; op_sel = op; src_a = a; src_b = breg; imm_val = imm; use_imm = ui;
    b = ui ? imm : breg;
    #2;
    if (v && op != 2'b11) f = ref_flags(op != 2'b00, a, b); else f = exp_flags;
    if (v && op == 2'b00) begin
      er = a + b;
      check(result == er, ui ? "R1/R10 add result" : "R1 add result", result, er);
      check(result_we == 1'b1, "R1 add we", {63'd0, result_we}, 64'd1);
    end else if (v && op == 2'b01) begin
      er = a - b;
      check(result == er, ui ? "R2/R10 sub result" : "R2 sub result", result, er);
      check(result_we == 1'b1, "R2 sub we", {63'd0, result_we}, 64'd1);
    end else begin
      check(result_we == 1'b0, "R3 no write-back", {63'd0, result_we}, 64'd0);
    end
    @(posedge clk); #1;
    exp_flags = f;
    if (v && op != 2'b11) begin
      check(flags_q[4:3] == f[4:3], "R4 SF/ZF", {58'd0, flags_q}, {58'd0, f});
      check(flags_q[0]   == f[0],   "R5 CF",    {58'd0, flags_q}, {58'd0, f});
      check(flags_q[5]   == f[5],   "R6 OF",    {58'd0, flags_q}, {58'd0, f});
      check(flags_q[2:1] == f[2:1], op == 2'b10 ? "R3/R7 AF/PF" : "R7 AF/PF", {58'd0, flags_q}, {58'd0, f});
    end else begin
      check(flags_q == f, "R8 flags hold", {58'd0, flags_q}, {58'd0, f});
    end
    eq = f[3];
    lt = !f[3] && (f[4] ^ f[5]);
    check({cond_gt, cond_eq, cond_lt, cond_below} == {!eq && !lt, eq, lt, f[0]},
          "R9 conditions", {60'd0, cond_gt, cond_eq, cond_lt, cond_below},
          {60'd0, !eq && !lt, eq, lt, f[0]});
  endtask

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  function automatic logic [63:0] pick();
    case ($urandom % 8)
      0: return 64'd0;
      1: return ONES;
      2: return MINV;
      3: return MINV - 1;
      4: return 64'd1;
      5: return {56'd0, 8'h0F};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_0A1B));
    rst_n = 0; op_valid = 0; op_sel = 0; use_imm = 0;
    src_a = 0; src_b = 0; imm_val = 0; exp_flags = '0;
    repeat (3) @(posedge clk);
    #1;
    check(flags_q == 6'd0, "R8 reset flags", {58'd0, flags_q}, 64'd0);
    check({cond_gt, cond_eq, cond_lt, cond_below} == 4'b1000, "R9 reset conditions",
          {60'd0, cond_gt, cond_eq, cond_lt, cond_below}, 64'h8);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    apply(1, 2'b00, ONES, 64'd1, 64'd0, 0);           // R5 carry, R4 zero
    apply(1, 2'b01, 64'd0, 64'd1, 64'd0, 0);          // R5 borrow
    apply(1, 2'b10, MINV, 64'd1, 64'd0, 0);           // R6 sub overflow, R9 lt
    apply(1, 2'b10, 64'd1, MINV, 64'd0, 0);           // R9 gt with OF
    apply(1, 2'b11, 64'd5, 64'd5, 64'd0, 0);          // R8 nop holds
    apply(0, 2'b00, 64'd5, 64'd7, 64'd0, 0);          // R8 invalid holds
    apply(1, 2'b10, 64'd42, 64'd0, 64'd42, 1);        // R10 imm, R9 eq
    apply(1, 2'b00, 64'h0F, 64'h01, 64'd0, 0);        // R7 adjust carry
    apply(1, 2'b01, 64'h10, 64'h01, 64'd0, 0);        // R7 adjust borrow
    apply(1, 2'b00, MINV - 1, 64'd1, 64'd0, 0);       // R6 add overflow
    apply(1, 2'b00, MINV, MINV, 64'd0, 0);            // R6/R4 overflow to zero
    apply(1, 2'b10, 64'd3, 64'd9, 64'd0, 0);          // R9 lt and below

    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      op = 2'($urandom % 4);
      apply(($urandom % 8) != 0, op, pick(), pick(), pick(), $urandom % 2);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule